// File: doc/BRIEF.md
# Scheduled Fault Injection Register Bank

This block is a test-support bank of output registers that can each be turned into a faulty register at a preloaded point in time. Before a run, a small schedule table is filled through a valid/ready load port. Every slot holds a target register, a fault value and an injection time in milliseconds. While the run is going, each iteration strobe moves an internal millisecond clock forward by a fixed step. On that same strobe, if injection is globally enabled, every scheduled fault whose time has been reached is applied to its target and then removed from the table.

A register without an applied fault stores whatever is written to it. Once its fault has been applied, it stores its fault value on every later write instead. The fault stays in place until reset. Applying a fault does not change the register's current contents; the faulty value appears only at the next write. This matches the rule that the selection between normal data and fault data is made at write time.

The load port applies back-pressure through `load_ready`, which is high exactly while the global enable is low. A beat moves into the table only in a cycle where `load_valid` and `load_ready` are both high. A producer that keeps `load_valid` high while the enable is high stalls, and nothing is written to the table. The producer must hold index, target, value and time stable until the beat is accepted.

Top module: `fault_sched_reg`

## Requirements
- R1: After reset, every register reads 0, no fault is active, `now_ms` is 0, and the table holds no scheduled fault.
- R2: `load_ready` equals the inverse of `inj_en`. A load beat offered while `inj_en` is high is not accepted and leaves the table unchanged.
- R3: Each cycle with `tick` high adds 100 to `now_ms`. With `tick` low, `now_ms` holds its value.
- R4: On a `tick` with `inj_en` high, every scheduled entry whose time is less than or equal to the new `now_ms` is applied: the bit of its target in `fault_active` is set at that edge, and the entry is removed from the table.
- R5: A write (`wr_en` with target `wr_idx`) to a register whose fault is not active stores `wr_data`. A write to a register whose fault is active stores that register's fault value.
- R6: While `inj_en` is low, no fault is applied and `fault_active` does not change. Entries that become due in that time stay scheduled and are applied at the first `tick` with `inj_en` high.
- R7: When several due entries target the same register in one check, the fault value comes from the entry with the lowest table index.
- R8: A due entry for a register whose fault is already active is removed from the table and does not change that register's fault value.
- R9: Applying a fault leaves the register contents unchanged. A write in the same cycle as the applying `tick` stores the normal `wr_data`.
- R10: An entry whose time equals the new `now_ms` is applied at that tick. An entry whose time is greater than the new `now_ms` is not applied.
- R11: Once active, a fault stays active, including after `inj_en` falls, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inj_en | input | 1 | Global injection enable; the table can be loaded only while this is low |
| tick | input | 1 | Iteration strobe; advances time and triggers the due check |
| load_valid | input | 1 | Load beat offered |
| load_ready | output | 1 | Load beat accepted when high together with `load_valid` |
| load_idx | input | 3 | Table slot to write |
| load_tgt | input | 2 | Target register of the scheduled fault |
| load_value | input | 16 | Fault value |
| load_time | input | 32 | Injection time in ms |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 2 | Register written |
| wr_data | input | 16 | Normal write data |
| reg_q | output | 64 | Register contents; register k occupies bits 16k+15 down to 16k |
| fault_active | output | 4 | Bit k is set once register k's fault has been applied |
| now_ms | output | 32 | Current time in ms |

## Verification
The two functions that can fall in one cycle are a fault being applied by a tick and a write to the same register. The bench drives `tick` and `wr_en` to one target in the same cycle, at the moment that target's entry becomes due. It then expects the written data, not the fault value, in the register, and expects the fault bit to be set. The following write to that register must then return the fault value. A second coincidence is several due entries for one target in a single check: the bench judges it by the value that later writes store.

// File: rtl/fi_pkg.sv
package fi_pkg;
  localparam int DEF_ENTRIES = 8;
  localparam int DEF_TARGETS = 4;
  localparam int DEF_VAL_W   = 16;
  localparam int DEF_TIME_W  = 32;
  localparam int DEF_STEP_MS = 100;
endpackage

// File: rtl/fi_timebase.sv
module fi_timebase #(
  parameter int TIME_W  = fi_pkg::DEF_TIME_W,
  parameter int STEP_MS = fi_pkg::DEF_STEP_MS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  output logic [TIME_W-1:0] now_q,
  output logic [TIME_W-1:0] now_next
);
  localparam logic [TIME_W-1:0] STEP_T = TIME_W'(STEP_MS);

  assign now_next = now_q + STEP_T;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    now_q <= '0;
    else if (tick) now_q <= now_next;
  end

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> now_q == $past(now_q) + STEP_T);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(now_q));
endmodule

// File: rtl/fi_table.sv
module fi_table #(
  parameter int ENTRIES = fi_pkg::DEF_ENTRIES,
  parameter int TARGETS = fi_pkg::DEF_TARGETS,
  parameter int VAL_W   = fi_pkg::DEF_VAL_W,
  parameter int TIME_W  = fi_pkg::DEF_TIME_W,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TGT_W  = $clog2(TARGETS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_fire,
  input  logic [IDX_W-1:0]         load_idx,
  input  logic [TGT_W-1:0]         load_tgt,
  input  logic [VAL_W-1:0]         load_value,
  input  logic [TIME_W-1:0]        load_time,
  input  logic                     check,
  input  logic [TIME_W-1:0]        cmp_time,
  output logic [ENTRIES-1:0]       due,
  output logic [ENTRIES*TGT_W-1:0] ent_tgt,
  output logic [ENTRIES*VAL_W-1:0] ent_val
);
  logic [ENTRIES-1:0] armed_q;
  logic [ENTRIES-1:0] ripe;
  logic [TGT_W-1:0]   tgt_q  [ENTRIES];
  logic [VAL_W-1:0]   val_q  [ENTRIES];
  logic [TIME_W-1:0]  when_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    assign ripe[i] = armed_q[i] && (when_q[i] <= cmp_time);
    assign ent_tgt[i*TGT_W +: TGT_W] = tgt_q[i];
    assign ent_val[i*VAL_W +: VAL_W] = val_q[i];

    always_ff @(posedge clk) begin
      if (load_fire && load_idx == IDX_W'(i)) begin
        tgt_q[i]  <= load_tgt;
        val_q[i]  <= load_value;
        when_q[i] <= load_time;
      end
    end

    p_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (check && ripe[i]) |=> !armed_q[i]);
  end

  assign due = check ? ripe : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= '0;
    end else if (check) begin
      armed_q <= armed_q & ~ripe;
    end else if (load_fire) begin
      armed_q[load_idx] <= 1'b1;
    end
  end

  p_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_fire && !check) |=> $stable(armed_q));
endmodule

// File: rtl/fi_select.sv
module fi_select #(
  parameter int ENTRIES = fi_pkg::DEF_ENTRIES,
  parameter int TARGETS = fi_pkg::DEF_TARGETS,
  parameter int VAL_W   = fi_pkg::DEF_VAL_W,
  localparam int TGT_W  = $clog2(TARGETS)
) (
  input  logic [ENTRIES-1:0]       due,
  input  logic [ENTRIES*TGT_W-1:0] ent_tgt,
  input  logic [ENTRIES*VAL_W-1:0] ent_val,
  output logic [TARGETS-1:0]       hit,
  output logic [TARGETS*VAL_W-1:0] hit_val
);
  for (genvar t = 0; t < TARGETS; t++) begin : g_tgt
    logic             hit_l;
    logic [VAL_W-1:0] val_l;

    always_comb begin
      hit_l = 1'b0;
      val_l = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
        if (due[i] && ent_tgt[i*TGT_W +: TGT_W] == TGT_W'(t)) begin
          hit_l = 1'b1;
          val_l = ent_val[i*VAL_W +: VAL_W];
        end
      end
    end

    assign hit[t] = hit_l;
    assign hit_val[t*VAL_W +: VAL_W] = val_l;
  end
endmodule

// File: rtl/fi_reg.sv
module fi_reg #(
  parameter int VAL_W = fi_pkg::DEF_VAL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inject,
  input  logic [VAL_W-1:0] inject_val,
  input  logic             wr_en,
  input  logic [VAL_W-1:0] wr_data,
  output logic [VAL_W-1:0] q,
  output logic             active
);
  logic [VAL_W-1:0] fval_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      fval_q <= '0;
    end else if (inject && !active) begin
      active <= 1'b1;
      fval_q <= inject_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= active ? fval_q : wr_data;
  end

  p_fault_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && active) |=> q == $past(fval_q));
  p_clean_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !active) |=> q == $past(wr_data));
  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> active);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
  p_first_val_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> $stable(fval_q));
endmodule

// File: rtl/fault_sched_reg.sv
module fault_sched_reg #(
  parameter int ENTRIES = fi_pkg::DEF_ENTRIES,
  parameter int TARGETS = fi_pkg::DEF_TARGETS,
  parameter int VAL_W   = fi_pkg::DEF_VAL_W,
  parameter int TIME_W  = fi_pkg::DEF_TIME_W,
  parameter int STEP_MS = fi_pkg::DEF_STEP_MS,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TGT_W  = $clog2(TARGETS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inj_en,
  input  logic                     tick,
  input  logic                     load_valid,
  output logic                     load_ready,
  input  logic [IDX_W-1:0]         load_idx,
  input  logic [TGT_W-1:0]         load_tgt,
  input  logic [VAL_W-1:0]         load_value,
  input  logic [TIME_W-1:0]        load_time,
  input  logic                     wr_en,
  input  logic [TGT_W-1:0]         wr_idx,
  input  logic [VAL_W-1:0]         wr_data,
  output logic [TARGETS*VAL_W-1:0] reg_q,
  output logic [TARGETS-1:0]       fault_active,
  output logic [TIME_W-1:0]        now_ms
);
  logic                     load_fire;
  logic                     check;
  logic [TIME_W-1:0]        now_next;
  logic [ENTRIES-1:0]       due;
  logic [ENTRIES*TGT_W-1:0] ent_tgt;
  logic [ENTRIES*VAL_W-1:0] ent_val;
  logic [TARGETS-1:0]       hit;
  logic [TARGETS*VAL_W-1:0] hit_val;

  assign load_ready = !inj_en;
  assign load_fire  = load_valid && load_ready;
  assign check      = tick && inj_en;

  fi_timebase #(.TIME_W(TIME_W), .STEP_MS(STEP_MS)) u_time (
    .clk(clk), .rst_n(rst_n), .tick(tick), .now_q(now_ms), .now_next(now_next)
  );

  fi_table #(.ENTRIES(ENTRIES), .TARGETS(TARGETS), .VAL_W(VAL_W), .TIME_W(TIME_W)) u_tab (
    .clk(clk), .rst_n(rst_n), .load_fire(load_fire), .load_idx(load_idx),
    .load_tgt(load_tgt), .load_value(load_value), .load_time(load_time),
    .check(check), .cmp_time(now_next), .due(due), .ent_tgt(ent_tgt), .ent_val(ent_val)
  );

  fi_select #(.ENTRIES(ENTRIES), .TARGETS(TARGETS), .VAL_W(VAL_W)) u_sel (
    .due(due), .ent_tgt(ent_tgt), .ent_val(ent_val), .hit(hit), .hit_val(hit_val)
  );

  for (genvar t = 0; t < TARGETS; t++) begin : g_reg
    fi_reg #(.VAL_W(VAL_W)) u_reg (
      .clk(clk), .rst_n(rst_n),
      .inject(hit[t]), .inject_val(hit_val[t*VAL_W +: VAL_W]),
      .wr_en(wr_en && wr_idx == TGT_W'(t)), .wr_data(wr_data),
      .q(reg_q[t*VAL_W +: VAL_W]), .active(fault_active[t])
    );
  end

  p_no_inject_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_en |=> fault_active == $past(fault_active));
  p_only_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> fault_active == $past(fault_active));
endmodule

// File: tb/sim_fault_sched_reg.sv
module sim_fault_sched_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inj_en = 1'b0, tick = 1'b0, load_valid = 1'b0, wr_en = 1'b0;
  logic        load_ready;
  logic [2:0]  load_idx = '0;
  logic [1:0]  load_tgt = '0, wr_idx = '0;
  logic [15:0] load_value = '0, wr_data = '0;
  logic [31:0] load_time = '0, now_ms;
  logic [63:0] reg_q;
  logic [3:0]  fault_active;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    int          kind;  // 0 reg, 1 fault bit, 2 time, 3 load_ready
    int          idx;
    logic [31:0] exp;
  } exp_t;
  exp_t sbq[$];

  always #5 clk = ~clk;

  fault_sched_reg u0 (
    .clk(clk), .rst_n(rst_n), .inj_en(inj_en), .tick(tick),
    .load_valid(load_valid), .load_ready(load_ready), .load_idx(load_idx),
    .load_tgt(load_tgt), .load_value(load_value), .load_time(load_time),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .reg_q(reg_q), .fault_active(fault_active), .now_ms(now_ms)
  );

  function automatic logic [31:0] observe(int kind, int idx);
    case (kind)
      0:       return {16'h0, reg_q[idx*16 +: 16]};
      1:       return {31'h0, fault_active[idx]};
      2:       return now_ms;
      default: return {31'h0, load_ready};
    endcase
  endfunction

  // monitor: pops expectations and compares against the ports
  initial begin
    exp_t e;
    logic [31:0] act;
    forever begin
      @(negedge clk);
      while (sbq.size() > 0) begin
        e = sbq.pop_front();
        act = observe(e.kind, e.idx);
        n_run++;
        if (act !== e.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h", e.tag, e.kind, e.idx, act, e.exp);
        end
      end
    end
  end

  task automatic push(string tag, int kind, int idx, logic [31:0] v);
    exp_t e;
    e.tag = tag; e.kind = kind; e.idx = idx; e.exp = v;
    sbq.push_back(e);
  endtask

  task automatic do_load(int idx, int tgt, logic [15:0] v, logic [31:0] t);
    @(negedge clk);
    load_valid = 1'b1; load_idx = 3'(idx); load_tgt = 2'(tgt);
    load_value = v; load_time = t;
    @(negedge clk);
    load_valid = 1'b0;
    #1;
  endtask

  task automatic do_write(int idx, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 2'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic do_tick(bit with_wr, int idx, logic [15:0] d);
    @(negedge clk);
    tick = 1'b1;
    if (with_wr) begin wr_en = 1'b1; wr_idx = 2'(idx); wr_data = d; end
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    #1;
  endtask

  task automatic set_en(logic v);
    @(negedge clk);
    inj_en = v;
    #1;
  endtask

  task automatic expect_faults(string tag, logic [3:0] v);
    for (int k = 0; k < 4; k++) push(tag, 1, k, {31'h0, v[k]});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    for (int k = 0; k < 4; k++) push("R1 reg", 0, k, 32'h0);
    expect_faults("R1 faults", 4'b0000);
    push("R1 time", 2, 0, 32'd0);
    push("R2 ready idle", 3, 0, 32'd1);

    // schedule while disabled
    do_load(0, 0, 16'hA000, 32'd200);
    do_load(1, 1, 16'hB111, 32'd100);
    do_load(2, 1, 16'hB222, 32'd100);
    do_load(3, 2, 16'hC333, 32'd300);
    do_load(4, 2, 16'hC444, 32'd500);
    do_load(5, 3, 16'hD555, 32'd50);
    do_write(0, 16'h1111);
    do_write(2, 16'h2220);
    push("R5 clean write", 0, 0, 32'h1111);
    push("R5 clean write", 0, 2, 32'h2220);

    // R6 tick while disabled: due entry not applied
    do_tick(0, 0, 16'h0);
    push("R3 step", 2, 0, 32'd100);
    expect_faults("R6 disabled", 4'b0000);

    set_en(1'b1);
    push("R2 ready low", 3, 0, 32'd0);
    // R2 rejected load would make reg2 due at once
    do_load(3, 2, 16'hEEEE, 32'd0);

    // R9 tick and write to reg1 in the same cycle
    do_tick(1, 1, 16'h1234);
    push("R3 step", 2, 0, 32'd200);
    expect_faults("R4 applied at 200 / R6 late / R2 rejected", 4'b1011);
    push("R9 same-cycle write", 0, 1, 32'h1234);
    push("R9 contents kept", 0, 0, 32'h1111);

    do_write(0, 16'h5555);
    push("R5 faulty write", 0, 0, 32'hA000);
    do_write(1, 16'h5555);
    push("R7 lowest index", 0, 1, 32'hB111);
    do_write(3, 16'h5555);
    push("R6 late value", 0, 3, 32'hD555);
    do_write(2, 16'h2222);
    push("R10 not yet due", 0, 2, 32'h2222);

    do_tick(0, 0, 16'h0);
    push("R3 step", 2, 0, 32'd300);
    expect_faults("R10 equal time", 4'b1111);
    do_write(2, 16'h7777);
    push("R10 value", 0, 2, 32'hC333);

    do_tick(0, 0, 16'h0);
    do_tick(0, 0, 16'h0);
    push("R3 step", 2, 0, 32'd500);
    do_write(2, 16'h8888);
    push("R8 first value kept", 0, 2, 32'hC333);

    set_en(1'b0);
    push("R2 ready back", 3, 0, 32'd1);
    expect_faults("R11 sticky", 4'b1111);
    do_write(0, 16'h9999);
    push("R11 still faulty", 0, 0, 32'hA000);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    expect_faults("R11 cleared by reset", 4'b0000);
    push("R1 time after reset", 2, 0, 32'd0);
    push("R1 reg after reset", 0, 0, 32'h0);
    // R1 table empty: enabled tick applies nothing
    set_en(1'b1);
    do_tick(0, 0, 16'h0);
    expect_faults("R1 table empty", 4'b0000);
    do_write(1, 16'h4321);
    push("R1 clean after reset", 0, 1, 32'h4321);

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule